// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a CPU load/store port and a slower memory. It holds single words in two directly indexed arrays: one array of tags with valid bits and one array of data. The word address is split into two fields. The low field selects one entry, and the high field is stored and compared. A read whose stored tag matches completes in the same cycle. A read that misses fetches the word from memory, returns it and installs it in the only entry its index allows, which evicts whatever that entry held.

Stores are write-through. Every store goes into a small queue of posted writes that drains to memory in the background, so the CPU waits only when that queue is full. A store that hits also updates the cached word. A store that misses leaves the arrays untouched (write-around). Before a read miss goes to memory, the queue is drained completely, so a fetch can never overtake an older store to the same word.

The CPU holds `cpu_req` and its fields stable until it sees `cpu_ready` high at a rising edge. `cpu_ready` is combinational and is high in the cycle the access completes.

Top module: `dm_wt_cache`

## Requirements
- R1: With the default parameters, byte address bits [1:0] are ignored, bits [5:2] form the 4-bit index and bits [11:6] form the 6-bit tag. Memory addresses are word addresses, equal to byte address bits [11:2].
- R2: A read whose indexed entry is valid with a matching tag completes in the cycle it is presented, returns the stored word and issues no memory read.
- R3: A read miss holds `mem_rd_req` with the word address until `mem_rd_valid`. In that cycle it completes with `mem_rd_data` and installs the word, so a repeat read hits.
- R4: Two addresses with the same index and different tags evict each other, and each re-read misses again. An address with a different index is not disturbed.
- R5: A store is accepted in the cycle it is presented when the write queue is not full. Accepted stores appear on the memory write port in acceptance order, with their word address and data.
- R6: While the write queue holds DEPTH (default 4) entries, a store is not accepted. It completes once memory drains an entry.
- R7: A store that hits updates the cached word, so a following read hits and returns the new value.
- R8: A store that misses does not change the cache. The word previously held at that index still hits, and a read of the stored address misses and fetches from memory.
- R9: After reset all entries are invalid, and the first read of any address misses.
- R10: A read miss issues no memory read while the write queue is non-empty, so it returns the value of an older queued store to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until completion |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| mem_wr_valid | output | 1 | Queued store available |
| mem_wr_ready | input | 1 | Memory takes the queued store |
| mem_wr_addr | output | ADDR_W-2 | Word address of queued store |
| mem_wr_data | output | DATA_W | Data of queued store |
| mem_rd_req | output | 1 | Fetch request, held until mem_rd_valid |
| mem_rd_addr | output | ADDR_W-2 | Word address to fetch |
| mem_rd_valid | input | 1 | Fetch data available |
| mem_rd_data | input | DATA_W | Fetched word |

## Verification
Corrupted tags or valid bits show up on the very next access to that index: either a read finishes with zero wait where a fetch was due, or a fetch appears where a zero-wait hit was due. Fill counts and wait cycles reveal both cases immediately. A wrong stored word shows as wrong `cpu_rdata` on the next hit. A wrong queue pointer or count shows as store data or order on the memory write port, or as a store that stalls when it should not (or fails to stall when it should), within DEPTH stores. A missing drain before a fetch shows only when a store is still queued to the word being read, so that case is set up with memory writes held off.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fsm_e;
endpackage

// File: rtl/cache_wbuf.sv
module cache_wbuf #(
    parameter int AW    = 10,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          full,
    output logic          empty,
    output logic          head_valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    input  logic          head_ready
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } wbuf_st_t;

    wbuf_st_t st_d, st_q;
    logic [AW+DW-1:0] slot_q [DEPTH];
    logic pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full       = (st_q.cnt == CNT_W'(DEPTH));
    assign empty      = (st_q.cnt == '0);
    assign head_valid = !empty;
    assign pop        = head_valid && head_ready;
    assign {head_addr, head_data} = slot_q[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = ptr_inc(st_q.wp);
        if (pop)  st_d.rp = ptr_inc(st_q.rp);
        st_d.cnt = st_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[st_q.wp] <= {push_addr, push_data};
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R6
    AST_POP_MOVES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));  // R5
endmodule

// File: rtl/cache_store.sv
module cache_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [DW-1:0]    rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [DW-1:0]      data_q [ENTRIES];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_data;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]);  // R3
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_ready,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [DW-1:0]    ent_data,
    output logic             ent_wr,
    output logic [DW-1:0]    ent_wr_data,
    input  logic             q_full,
    input  logic             q_empty,
    output logic             q_push,
    output logic             mem_rd_req,
    input  logic             mem_rd_valid,
    input  logic [DW-1:0]    mem_rd_data
);
    typedef struct packed {
        fsm_e st;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic hit;

    assign hit = ent_valid && (ent_tag == req_tag);

    always_comb begin
        st_d        = st_q;
        cpu_ready   = 1'b0;
        cpu_rdata   = ent_data;
        ent_wr      = 1'b0;
        ent_wr_data = cpu_wdata;
        q_push      = 1'b0;
        mem_rd_req  = 1'b0;
        unique case (st_q.st)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    if (!q_full) begin
                        cpu_ready = 1'b1;
                        q_push    = 1'b1;
                        ent_wr    = hit;
                    end
                end else if (cpu_req) begin
                    if (hit)          cpu_ready = 1'b1;
                    else if (q_empty) st_d.st   = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                if (mem_rd_valid) begin
                    cpu_ready   = 1'b1;
                    cpu_rdata   = mem_rd_data;
                    ent_wr      = 1'b1;
                    ent_wr_data = mem_rd_data;
                    st_d.st     = ST_IDLE;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_IDLE};
        else        st_q <= st_d;
    end

    AST_FETCH_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> q_empty);  // R10
    AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> mem_rd_req);  // R3
    AST_STORE_STALLS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && q_full) |-> !cpu_ready);  // R6
    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && hit && !mem_rd_req) |=> !mem_rd_req);  // R2
    AST_WRMISS_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !hit) |-> !ent_wr);  // R8
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic                cpu_ready,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-3:0]   mem_wr_addr,
    output logic [DATA_W-1:0]   mem_wr_data,
    output logic                mem_rd_req,
    output logic [ADDR_W-3:0]   mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [DATA_W-1:0]   mem_rd_data
);
    localparam int OFF_W = 2;
    localparam int WA_W  = ADDR_W - OFF_W;
    localparam int TAG_W = WA_W - IDX_W;

    logic [WA_W-1:0]  word_addr;
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic             off_unused;

    assign word_addr  = cpu_addr[ADDR_W-1:OFF_W];
    assign req_idx    = word_addr[IDX_W-1:0];
    assign req_tag    = word_addr[WA_W-1:IDX_W];
    assign off_unused = ^cpu_addr[OFF_W-1:0];
    assign mem_rd_addr = word_addr;

    logic             ent_valid, ent_wr, q_full, q_empty, q_push;
    logic [TAG_W-1:0] ent_tag;
    logic [DATA_W-1:0] ent_data, ent_wr_data;

    cache_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(req_idx), .rd_valid(ent_valid), .rd_tag(ent_tag), .rd_data(ent_data),
        .wr_en(ent_wr), .wr_idx(req_idx), .wr_tag(req_tag), .wr_data(ent_wr_data)
    );

    cache_wbuf #(.AW(WA_W), .DW(DATA_W), .DEPTH(DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_addr(word_addr), .push_data(cpu_wdata),
        .full(q_full), .empty(q_empty),
        .head_valid(mem_wr_valid), .head_addr(mem_wr_addr), .head_data(mem_wr_data),
        .head_ready(mem_wr_ready)
    );

    cache_ctrl #(.TAG_W(TAG_W), .DW(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .req_tag(req_tag), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .ent_valid(ent_valid), .ent_tag(ent_tag), .ent_data(ent_data),
        .ent_wr(ent_wr), .ent_wr_data(ent_wr_data),
        .q_full(q_full), .q_empty(q_empty), .q_push(q_push),
        .mem_rd_req(mem_rd_req), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    AST_STORE_POSTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |=> mem_wr_valid);  // R5
endmodule

// File: tb/tb_dm_wt_cache.sv
module tb_dm_wt_cache;
    localparam int AW = 12, DW = 32, WA = 10, DEPTH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpu_req = 0, cpu_we = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ready, mem_wr_valid, mem_wr_ready = 1'b1, mem_rd_req, mem_rd_valid = 1'b0;
    logic [WA-1:0] mem_wr_addr, mem_rd_addr;
    logic [DW-1:0] mem_wr_data, mem_rd_data = '0;

    always #4 clk = ~clk;

    dm_wt_cache dut (.*);

    logic [DW-1:0] mem [1 << WA];
    logic [WA-1:0] wlog [64];
    int wcnt = 0, fills = 0, rd_cnt = 0;
    logic [WA-1:0] last_rd_addr;
    int checks = 0, fails = 0;
    bit done = 0;

    function automatic logic [DW-1:0] fv(input int w);
        return 32'hA000_0000 | w;
    endfunction

    always @(posedge clk) begin
        if (mem_wr_valid && mem_wr_ready) begin
            mem[mem_wr_addr] <= mem_wr_data;
            wlog[wcnt[5:0]] <= mem_wr_addr;
            wcnt <= wcnt + 1;
        end
        mem_rd_valid <= 1'b0;
        if (mem_rd_req && !mem_rd_valid) begin
            if (rd_cnt == 1) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[mem_rd_addr];
                last_rd_addr <= mem_rd_addr;
                fills        <= fills + 1;
                rd_cnt       <= 0;
            end else rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        cyc = 0;
        while (1) begin
            #1;
            if (cpu_ready || cyc > 500) break;
            @(negedge clk);
            cyc++;
        end
        rd = cpu_rdata;
        @(negedge clk);
        cpu_req = 0; cpu_we = 0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (mem_wr_valid) @(negedge clk);
    endtask

    logic [DW-1:0] rd;
    int cyc, f0;

    task automatic t_reset();
        @(negedge clk);
        chk(!cpu_ready && !mem_rd_req && !mem_wr_valid, "R9 idle after reset",
            {cpu_ready, mem_rd_req, mem_wr_valid}, 0);
    endtask

    task automatic t_cold_miss();
        f0 = fills;
        access(0, 12'h140, 0, rd, cyc);
        chk(fills == f0 + 1 && cyc > 0, "R9 first read misses", fills - f0, 1);
        chk(rd == fv('h50), "R3 miss returns memory word", rd, fv('h50));
        chk(last_rd_addr == 10'h50, "R1 fetch uses word address", last_rd_addr, 10'h50);
    endtask

    task automatic t_hit();
        f0 = fills;
        access(0, 12'h140, 0, rd, cyc);
        chk(cyc == 0 && fills == f0, "R2 repeat read hits", cyc, 0);
        chk(rd == fv('h50), "R2 hit data", rd, fv('h50));
        access(0, 12'h143, 0, rd, cyc);
        chk(cyc == 0 && rd == fv('h50), "R1 byte offset ignored", rd, fv('h50));
    endtask

    task automatic t_conflict();
        f0 = fills;
        access(0, 12'h240, 0, rd, cyc);
        chk(fills == f0 + 1 && rd == fv('h90), "R4 same index other tag misses", rd, fv('h90));
        access(0, 12'h084, 0, rd, cyc);
        access(0, 12'h140, 0, rd, cyc);
        chk(fills == f0 + 3 && rd == fv('h50), "R4 evicted word misses again", fills - f0, 3);
        access(0, 12'h084, 0, rd, cyc);
        chk(cyc == 0 && rd == fv('h21), "R4 other index untouched", rd, fv('h21));
    endtask

    task automatic t_write_hit();
        access(1, 12'h140, 32'h1111, rd, cyc);
        chk(cyc == 0, "R5 store accepted at once", cyc, 0);
        access(0, 12'h140, 0, rd, cyc);
        chk(cyc == 0 && rd == 32'h1111, "R7 write hit updates entry", rd, 32'h1111);
        drain();
        chk(mem[10'h50] == 32'h1111, "R5 store reaches memory", mem[10'h50], 32'h1111);
    endtask

    task automatic t_write_miss();
        access(1, 12'h300, 32'h2222, rd, cyc);
        drain();
        access(0, 12'h140, 0, rd, cyc);
        chk(cyc == 0 && rd == 32'h1111, "R8 write miss keeps resident word", rd, 32'h1111);
        f0 = fills;
        access(0, 12'h300, 0, rd, cyc);
        chk(fills == f0 + 1 && rd == 32'h2222, "R8 write miss not allocated", fills - f0, 1);
    endtask

    task automatic t_order();
        int w0;
        w0 = wcnt;
        access(1, 12'h010, 32'h1, rd, cyc);
        access(1, 12'h3F0, 32'h2, rd, cyc);
        access(1, 12'h020, 32'h3, rd, cyc);
        drain();
        chk(wlog[w0] == 10'h004 && wlog[w0+1] == 10'h0FC && wlog[w0+2] == 10'h008,
            "R5 memory writes in order", wlog[w0+1], 10'h0FC);
    endtask

    task automatic t_full();
        @(negedge clk); mem_wr_ready = 0;
        for (int i = 0; i < DEPTH; i++) begin
            access(1, AW'(12'h400 + i * 4), DW'(i), rd, cyc);
            chk(cyc == 0, "R6 store accepted while not full", cyc, 0);
        end
        fork
            access(1, 12'h500, 32'h55, rd, cyc);
            begin repeat (6) @(negedge clk); mem_wr_ready = 1; end
        join
        chk(cyc >= 5, "R6 store stalls when full", cyc, 5);
        drain();
        chk(mem[10'h140] == 32'h55, "R6 stalled store completes", mem[10'h140], 32'h55);
    endtask

    task automatic t_drain();
        @(negedge clk); mem_wr_ready = 0;
        access(1, 12'h0CC, 32'h3333, rd, cyc);
        f0 = fills;
        fork
            access(0, 12'h0CC, 0, rd, cyc);
            begin repeat (6) @(negedge clk); mem_wr_ready = 1; end
        join
        chk(rd == 32'h3333 && cyc >= 6, "R10 fetch waits for queued store", rd, 32'h3333);
        chk(fills == f0 + 1, "R10 single fetch", fills - f0, 1);
    endtask

    initial begin
        for (int i = 0; i < (1 << WA); i++) mem[i] = fv(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_cold_miss();
        t_hit();
        t_conflict();
        t_write_hit();
        t_write_miss();
        t_order();
        t_full();
        t_drain();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule